// File: doc/BRIEF.md
# Framebuffer Write Data Expander

This block sits between a host write port and a byte-wide pixel memory. Each accepted host word, together with a position, an access size and a row counter, becomes a short burst of single-byte pixel writes. The access-mode register selects how the word is read. It can be four packed bytes placed at a linear address (byte-swapped), four packed bytes placed at an XY-derived address (with two ways of reading the position), or a monochrome bitmap whose bits become foreground and background pixels. When the burst ends the block returns the position the host should use for its next write, advanced by a step that depends on the mode.

Configuration lives in four small registers written through a simple write strobe: the access mode, a 32-bit bit mask, an image-operation word and a plane mask. Pixel writes leave one per cycle under a valid/ready handshake and carry the low byte of the plane mask as a per-bit write enable for the memory. A one-cycle done pulse ends every request, including requests that produce no pixels.

Top module: `fb_pixel_expander`

## Requirements
- R1: After reset the image-operation word is 0x23000300 (bit 29 set, bits 28 and 1 clear), the plane mask is 0xff (seen on `pix_wmask`), the bit mask is 0xffffffff and the access mode is 0. A request made in this state produces no pixel writes and returns the position unchanged.
- R2: With access mode bits [31:16] equal to 0x3ba0 or 0xbbe0, the word is byte-swapped. Byte k (bits 8k+7..8k) is written to linear offset pos+k for k = 0..3, and the returned position is pos+4.
- R3: With mode 0x1360, byte k taken from the most significant end (bits 31-8k..24-8k) is written to XY offset base+k, and the returned position is pos+4. The XY offset of a word w is (w[20:11] + req_row) × FB_WIDTH + w[10:0].
- R4: With mode 0x13a0, the bytes are placed as in R3, but the XY offset is computed from pos shifted right by 2. The returned position is pos+16.
- R5: In the four-byte modes (R2 to R4), when image-operation bit 29 is set, byte k is written only if bit 31-k of the bit mask is 1. When bit 29 is clear, no byte is masked.
- R6: With mode 0x2ea0 the block emits size×8 pixels (size 1, 2 or 4). The XY offset comes from pos shifted right by 2. Pixel i goes to offset+i and takes data bit size×8-1-i, so the most significant bit comes first. A 1 bit writes the foreground colour and a 0 bit the background colour. The returned position is pos+4.
- R7: Mode 0x28a0 behaves as R6 but writes the value 1 for a set bit and 0 for a clear bit.
- R8: In the bit-expand modes, when image-operation bit 29 is set, pixel i is gated by bit size×8-1-i of the bit mask shifted right by (4-size)×8.
- R9: In the bit-expand modes, when image-operation bit 28 or bit 1 is set, a 0 data bit writes nothing.
- R10: A pixel whose offset is at or beyond FB_WIDTH × FB_HEIGHT is not written. The other pixels of the same request are still written.
- R11: Any other access-mode value produces no pixel writes and returns the position unchanged.
- R12: `req_ready` is high only when no request is in progress. A pixel write stays valid with stable address and data until it is accepted. `done` is high for exactly one cycle after the last write, and `next_pos` is valid while `done` is high.
- R13: A configuration write selects its register with `cfg_addr`: 0 access mode, 1 bit mask, 2 image operation, 3 plane mask. The low 8 bits of the plane mask drive `pix_wmask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Host write request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_data | input | 32 | Host write data |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_pos | input | 32 | Current position word |
| req_row | input | ROW_CNT_W | Row counter added to the row field |
| fg_color | input | 8 | Foreground colour |
| bg_color | input | 8 | Background colour |
| pix_valid | output | 1 | Pixel write valid |
| pix_ready | input | 1 | Pixel write accepted by memory |
| pix_addr | output | ADDR_W | Pixel byte offset |
| pix_data | output | 8 | Pixel byte value |
| pix_wmask | output | 8 | Per-bit write enable (plane mask) |
| done | output | 1 | One-cycle end-of-request pulse |
| next_pos | output | 32 | Updated position, valid with done |

## Verification
A wrong slot index or lane select shows up as a swapped or shifted byte on `pix_addr`/`pix_data`, at the first write of the request. A wrong gating decision for the mask, transparency or range check shows up as a missing or extra write in the stream, so the pixel count for the request is wrong by the time `done` pulses. A wrong step or decode shows up only on `next_pos` during the `done` cycle. For that reason the sweep compares every write and the returned position of every request. It covers all modes, image-operation variants, masks, sizes and positions that straddle the end of the buffer, and it applies ready backpressure on alternate requests.

// File: rtl/fbx_pkg.sv
package fbx_pkg;

    typedef enum logic [2:0] {
        MK_NONE,
        MK_SWAP_LIN,
        MK_XY_BYTE,
        MK_XY_WORD,
        MK_BIT_COLOR,
        MK_BIT_UNIT
    } mode_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE
    } seq_st_e;

    localparam logic [15:0] SEL_SWAP_A    = 16'h3ba0;
    localparam logic [15:0] SEL_SWAP_B    = 16'hbbe0;
    localparam logic [15:0] SEL_XY_BYTE   = 16'h1360;
    localparam logic [15:0] SEL_XY_WORD   = 16'h13a0;
    localparam logic [15:0] SEL_BIT_COLOR = 16'h2ea0;
    localparam logic [15:0] SEL_BIT_UNIT  = 16'h28a0;

    localparam logic [1:0] CFG_MODE  = 2'd0;
    localparam logic [1:0] CFG_MASK  = 2'd1;
    localparam logic [1:0] CFG_OP    = 2'd2;
    localparam logic [1:0] CFG_PLANE = 2'd3;

    localparam int OP_MASK_EN = 29;
    localparam int OP_TRANSP  = 28;
    localparam int OP_TRANSP2 = 1;

    localparam logic [31:0] OP_RESET    = 32'h2300_0300;
    localparam logic [7:0]  PLANE_RESET = 8'hff;
    localparam logic [31:0] MASK_RESET  = 32'hffff_ffff;

    // image-op bits kept in hardware: {mask enable, transparency a, transparency b}
    typedef struct packed {
        logic mask_en;
        logic transp_a;
        logic transp_b;
    } op_bits_t;

    function automatic mode_kind_e decode_mode(input logic [15:0] sel);
        mode_kind_e k;
        case (sel)
            SEL_SWAP_A, SEL_SWAP_B: k = MK_SWAP_LIN;
            SEL_XY_BYTE:            k = MK_XY_BYTE;
            SEL_XY_WORD:            k = MK_XY_WORD;
            SEL_BIT_COLOR:          k = MK_BIT_COLOR;
            SEL_BIT_UNIT:           k = MK_BIT_UNIT;
            default:                k = MK_NONE;
        endcase
        return k;
    endfunction

    function automatic logic is_bit_kind(input mode_kind_e k);
        return (k == MK_BIT_COLOR) || (k == MK_BIT_UNIT);
    endfunction

    function automatic logic [5:0] slot_count(input mode_kind_e k, input logic [2:0] sz);
        logic [2:0] s;
        logic [5:0] n;
        s = (sz > 3'd4) ? 3'd4 : sz;
        case (k)
            MK_NONE:                   n = 6'd0;
            MK_BIT_COLOR, MK_BIT_UNIT: n = {s, 3'b000};
            default:                   n = 6'd4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/fbx_cfg_regs.sv
module fbx_cfg_regs
    import fbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [15:0] mode_sel,
    output logic [31:0] bit_mask,
    output op_bits_t    op_bits,
    output logic [7:0]  plane_mask
);

    typedef struct packed {
        logic [15:0] mode;
        logic [31:0] mask;
        op_bits_t    op;
        logic [7:0]  plane;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            case (cfg_addr)
                CFG_MODE:  cfg_d.mode  = cfg_wdata[31:16];
                CFG_MASK:  cfg_d.mask  = cfg_wdata;
                CFG_OP:    cfg_d.op    = '{cfg_wdata[OP_MASK_EN], cfg_wdata[OP_TRANSP],
                                           cfg_wdata[OP_TRANSP2]};
                default:   cfg_d.plane = cfg_wdata[7:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mode  <= 16'h0000;
            cfg_q.mask  <= MASK_RESET;
            cfg_q.op    <= '{OP_RESET[OP_MASK_EN], OP_RESET[OP_TRANSP], OP_RESET[OP_TRANSP2]};
            cfg_q.plane <= PLANE_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode_sel   = cfg_q.mode;
    assign bit_mask   = cfg_q.mask;
    assign op_bits    = cfg_q.op;
    assign plane_mask = cfg_q.plane;

endmodule

// File: rtl/fbx_xy_offset.sv
module fbx_xy_offset
    import fbx_pkg::*;
#(
    parameter int FB_WIDTH  = 64,
    parameter int COL_BITS  = 11,
    parameter int ROW_BITS  = 10,
    parameter int ROW_CNT_W = 10
) (
    input  mode_kind_e             kind,
    input  logic [31:0]            pos,
    input  logic [ROW_CNT_W-1:0]   row_cnt,
    output logic [31:0]            base,
    output logic [31:0]            step
);

    localparam logic [31:0] COL_MASK = (32'd1 << COL_BITS) - 32'd1;
    localparam logic [31:0] ROW_MASK = (32'd1 << ROW_BITS) - 32'd1;

    logic [31:0] word;
    logic [31:0] row_w;
    logic [31:0] xy;

    always_comb begin
        // word-addressed modes see the position in units of four
        word  = (kind == MK_XY_WORD || is_bit_kind(kind)) ? (pos >> 2) : pos;
        row_w = ((word >> COL_BITS) & ROW_MASK) + 32'(row_cnt);
        xy    = row_w * 32'(FB_WIDTH) + (word & COL_MASK);
        base  = (kind == MK_SWAP_LIN) ? pos : xy;
        case (kind)
            MK_NONE:    step = 32'd0;
            MK_XY_WORD: step = 32'd16;
            default:    step = 32'd4;
        endcase
    end

endmodule

// File: rtl/fbx_slot_gen.sv
module fbx_slot_gen
    import fbx_pkg::*;
#(
    parameter int BUF_SIZE = 2048,
    parameter int ADDR_W   = 11
) (
    input  mode_kind_e        kind,
    input  logic [31:0]       data,
    input  logic [2:0]        size,
    input  logic [31:0]       mask,
    input  op_bits_t          op,
    input  logic [7:0]        fg,
    input  logic [7:0]        bg,
    input  logic [31:0]       base,
    input  logic [4:0]        idx,
    output logic              emit,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        value
);

    logic [32:0] off;
    logic        in_range;
    logic [2:0]  sz;
    logic [5:0]  nbits;
    logic [5:0]  dsel;
    logic        dbit;
    logic        want;
    logic        masked_out;

    always_comb begin
        off      = {1'b0, base} + 33'(idx);
        in_range = off < 33'(BUF_SIZE);
        sz       = (size > 3'd4) ? 3'd4 : size;
        nbits    = {sz, 3'b000};
        dsel     = nbits - 6'd1 - {1'b0, idx};
        dbit     = data[dsel[4:0]];
        // right-aligning the mask by (4-size) bytes lines slot i up with bit 31-i
        masked_out = op.mask_en && !mask[5'd31 - idx];
        value    = 8'h00;
        want     = 1'b0;
        case (kind)
            MK_SWAP_LIN: begin
                value = data[{idx[1:0], 3'b000} +: 8];
                want  = 1'b1;
            end
            MK_XY_BYTE, MK_XY_WORD: begin
                value = data[{~idx[1:0], 3'b000} +: 8];
                want  = 1'b1;
            end
            MK_BIT_COLOR: begin
                value = dbit ? fg : bg;
                want  = dbit || !(op.transp_a || op.transp_b);
            end
            MK_BIT_UNIT: begin
                value = dbit ? 8'd1 : 8'd0;
                want  = dbit || !(op.transp_a || op.transp_b);
            end
            default: begin
                value = 8'h00;
                want  = 1'b0;
            end
        endcase
        emit = want && !masked_out && in_range;
        addr = off[ADDR_W-1:0];
    end

endmodule

// File: rtl/fbx_burst_seq.sv
module fbx_burst_seq
    import fbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_data,
    input  logic [2:0]  req_size,
    input  logic [31:0] req_pos,
    input  mode_kind_e  req_kind,
    input  logic [31:0] req_base,
    input  logic [31:0] req_step,
    input  logic [31:0] cfg_mask,
    input  op_bits_t    cfg_op,
    input  logic [7:0]  req_fg,
    input  logic [7:0]  req_bg,
    input  logic        slot_emit,
    input  logic        pix_ready,
    output mode_kind_e  cur_kind,
    output logic [31:0] cur_data,
    output logic [2:0]  cur_size,
    output logic [31:0] cur_mask,
    output op_bits_t    cur_op,
    output logic [7:0]  cur_fg,
    output logic [7:0]  cur_bg,
    output logic [31:0] cur_base,
    output logic [4:0]  cur_idx,
    output logic        pix_valid,
    output logic        done,
    output logic [31:0] next_pos
);

    typedef struct packed {
        seq_st_e     st;
        mode_kind_e  kind;
        logic [4:0]  idx;
        logic [5:0]  count;
        logic [31:0] data;
        logic [2:0]  size;
        logic [31:0] mask;
        op_bits_t    op;
        logic [7:0]  fg;
        logic [7:0]  bg;
        logic [31:0] base;
        logic [31:0] npos;
    } seq_t;

    seq_t s_d, s_q;
    logic last;

    always_comb begin
        s_d       = s_q;
        req_ready = (s_q.st == ST_IDLE);
        pix_valid = (s_q.st == ST_RUN) && slot_emit;
        done      = (s_q.st == ST_DONE);
        last      = ({1'b0, s_q.idx} == (s_q.count - 6'd1));
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.kind  = req_kind;
                    s_d.data  = req_data;
                    s_d.size  = req_size;
                    s_d.mask  = cfg_mask;
                    s_d.op    = cfg_op;
                    s_d.fg    = req_fg;
                    s_d.bg    = req_bg;
                    s_d.base  = req_base;
                    s_d.npos  = req_pos + req_step;
                    s_d.idx   = 5'd0;
                    s_d.count = slot_count(req_kind, req_size);
                    s_d.st    = (slot_count(req_kind, req_size) == 6'd0) ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN: begin
                // suppressed slots cost one cycle and never wait on the memory
                if (!slot_emit || pix_ready) begin
                    if (last) begin
                        s_d.st = ST_DONE;
                    end else begin
                        s_d.idx = s_q.idx + 5'd1;
                    end
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.kind <= MK_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_kind = s_q.kind;
    assign cur_data = s_q.data;
    assign cur_size = s_q.size;
    assign cur_mask = s_q.mask;
    assign cur_op   = s_q.op;
    assign cur_fg   = s_q.fg;
    assign cur_bg   = s_q.bg;
    assign cur_base = s_q.base;
    assign cur_idx  = s_q.idx;
    assign next_pos = s_q.npos;

endmodule

// File: rtl/fb_pixel_expander.sv
module fb_pixel_expander
    import fbx_pkg::*;
#(
    parameter int FB_WIDTH  = 64,
    parameter int FB_HEIGHT = 32,
    parameter int COL_BITS  = 11,
    parameter int ROW_BITS  = 10,
    parameter int ROW_CNT_W = 10,
    localparam int BUF_SIZE = FB_WIDTH * FB_HEIGHT,
    localparam int ADDR_W   = $clog2(BUF_SIZE)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_addr,
    input  logic [31:0]          cfg_wdata,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [31:0]          req_data,
    input  logic [2:0]           req_size,
    input  logic [31:0]          req_pos,
    input  logic [ROW_CNT_W-1:0] req_row,
    input  logic [7:0]           fg_color,
    input  logic [7:0]           bg_color,
    output logic                 pix_valid,
    input  logic                 pix_ready,
    output logic [ADDR_W-1:0]    pix_addr,
    output logic [7:0]           pix_data,
    output logic [7:0]           pix_wmask,
    output logic                 done,
    output logic [31:0]          next_pos
);

    logic [15:0] cfg_mode;
    logic [31:0] cfg_mask;
    op_bits_t    cfg_op;
    logic [7:0]  cfg_plane;
    mode_kind_e  req_kind;
    logic [31:0] req_base;
    logic [31:0] req_step;

    mode_kind_e  cur_kind;
    logic [31:0] cur_data;
    logic [2:0]  cur_size;
    logic [31:0] cur_mask;
    op_bits_t    cur_op;
    logic [7:0]  cur_fg;
    logic [7:0]  cur_bg;
    logic [31:0] cur_base;
    logic [4:0]  cur_idx;
    logic        slot_emit;

    fbx_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .mode_sel   (cfg_mode),
        .bit_mask   (cfg_mask),
        .op_bits    (cfg_op),
        .plane_mask (cfg_plane)
    );

    assign req_kind  = decode_mode(cfg_mode);
    assign pix_wmask = cfg_plane;

    fbx_xy_offset #(
        .FB_WIDTH  (FB_WIDTH),
        .COL_BITS  (COL_BITS),
        .ROW_BITS  (ROW_BITS),
        .ROW_CNT_W (ROW_CNT_W)
    ) u_xy (
        .kind    (req_kind),
        .pos     (req_pos),
        .row_cnt (req_row),
        .base    (req_base),
        .step    (req_step)
    );

    fbx_burst_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_data  (req_data),
        .req_size  (req_size),
        .req_pos   (req_pos),
        .req_kind  (req_kind),
        .req_base  (req_base),
        .req_step  (req_step),
        .cfg_mask  (cfg_mask),
        .cfg_op    (cfg_op),
        .req_fg    (fg_color),
        .req_bg    (bg_color),
        .slot_emit (slot_emit),
        .pix_ready (pix_ready),
        .cur_kind  (cur_kind),
        .cur_data  (cur_data),
        .cur_size  (cur_size),
        .cur_mask  (cur_mask),
        .cur_op    (cur_op),
        .cur_fg    (cur_fg),
        .cur_bg    (cur_bg),
        .cur_base  (cur_base),
        .cur_idx   (cur_idx),
        .pix_valid (pix_valid),
        .done      (done),
        .next_pos  (next_pos)
    );

    fbx_slot_gen #(
        .BUF_SIZE (BUF_SIZE),
        .ADDR_W   (ADDR_W)
    ) u_slot (
        .kind  (cur_kind),
        .data  (cur_data),
        .size  (cur_size),
        .mask  (cur_mask),
        .op    (cur_op),
        .fg    (cur_fg),
        .bg    (cur_bg),
        .base  (cur_base),
        .idx   (cur_idx),
        .emit  (slot_emit),
        .addr  (pix_addr),
        .value (pix_data)
    );

endmodule

// File: rtl/fbx_checker.sv
module fbx_checker
    import fbx_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [31:0]       req_pos,
    input logic [15:0]       mode_sel,
    input logic              pix_valid,
    input logic              pix_ready,
    input logic [ADDR_W-1:0] pix_addr,
    input logic [7:0]        pix_data,
    input logic              done,
    input logic [31:0]       next_pos
);

    assert_pix_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_addr) && $stable(pix_data)));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!pix_valid && !done));

    assert_unknown_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && decode_mode(mode_sel) == MK_NONE)
        |=> (done && !pix_valid && next_pos == $past(req_pos)));

endmodule

bind fb_pixel_expander fbx_checker #(.ADDR_W(ADDR_W)) u_fbx_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_pos   (req_pos),
    .mode_sel  (cfg_mode),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .pix_addr  (pix_addr),
    .pix_data  (pix_data),
    .done      (done),
    .next_pos  (next_pos)
);

// File: tb/fb_pixel_expander_bench.sv
module fb_pixel_expander_bench;

    localparam int FBW  = 64;
    localparam int FBH  = 32;
    localparam int BUFN = FBW * FBH;
    localparam int AW   = $clog2(BUFN);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [31:0]   req_data = '0;
    logic [2:0]    req_size = 3'd4;
    logic [31:0]   req_pos = '0;
    logic [9:0]    req_row = '0;
    logic [7:0]    fg_color = '0;
    logic [7:0]    bg_color = '0;
    logic          pix_valid;
    logic          pix_ready = 1'b1;
    logic [AW-1:0] pix_addr;
    logic [7:0]    pix_data;
    logic [7:0]    pix_wmask;
    logic          done;
    logic [31:0]   next_pos;

    fb_pixel_expander #(.FB_WIDTH(FBW), .FB_HEIGHT(FBH)) u_fb_pixel_expander (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
        .req_valid, .req_ready, .req_data, .req_size, .req_pos, .req_row,
        .fg_color, .bg_color, .pix_valid, .pix_ready, .pix_addr, .pix_data,
        .pix_wmask, .done, .next_pos
    );

    always #4 clk = ~clk;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  summary_done = 1'b0;

    // bench copy of the configuration, from the register map of R13
    logic [31:0] m_mode  = 32'h0;
    logic [31:0] m_mask  = 32'hffff_ffff;
    logic [31:0] m_op    = 32'h2300_0300;
    logic [7:0]  m_plane = 8'hff;

    logic [31:0] exp_addr [0:31];
    logic [7:0]  exp_dat  [0:31];
    int          exp_n;
    logic [31:0] exp_pos;
    logic [7:0]  mem [0:BUFN-1];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            2'd0:    m_mode  = d;
            2'd1:    m_mask  = d;
            2'd2:    m_op    = d;
            default: m_plane = d[7:0];
        endcase
    endtask

    function automatic longint xy_of(input logic [31:0] w, input int rw);
        return (longint'((w >> 11) & 32'h3ff) + longint'(rw)) * FBW + longint'(w & 32'h7ff);
    endfunction

    function automatic string tag_of(input logic [15:0] m);
        case (m)
            16'h3ba0, 16'hbbe0: return "R2 R5 R10";
            16'h1360:           return "R3 R5 R10";
            16'h13a0:           return "R4 R5 R10";
            16'h2ea0:           return "R6 R8 R9 R10";
            16'h28a0:           return "R7 R8 R9 R10";
            default:            return "R11";
        endcase
    endfunction

    task automatic build_expect(input logic [31:0] d, input int sz, input logic [31:0] p,
                                input int rw, input logic [7:0] fg, input logic [7:0] bg);
        logic [15:0] m;
        longint      base;
        logic [31:0] sm;
        bit          b, ok, unit;
        int          n;
        m = m_mode[31:16];
        exp_n = 0;
        exp_pos = p;
        if (m == 16'h3ba0 || m == 16'hbbe0 || m == 16'h1360 || m == 16'h13a0) begin
            if (m == 16'h1360)      base = xy_of(p, rw);
            else if (m == 16'h13a0) base = xy_of(p >> 2, rw);
            else                    base = longint'(p);
            exp_pos = p + ((m == 16'h13a0) ? 32'd16 : 32'd4);
            for (int k = 0; k < 4; k++) begin
                ok = (!m_op[29] || m_mask[31-k]) && (base + k < BUFN);
                if (ok) begin
                    exp_addr[exp_n] = 32'(base + k);
                    exp_dat[exp_n]  = (m == 16'h3ba0 || m == 16'hbbe0) ?
                                      d[8*k +: 8] : d[31-8*k -: 8];
                    exp_n++;
                end
            end
        end else if (m == 16'h2ea0 || m == 16'h28a0) begin
            unit = (m == 16'h28a0);
            base = xy_of(p >> 2, rw);
            exp_pos = p + 32'd4;
            n  = sz * 8;
            sm = m_mask >> ((4 - sz) * 8);
            for (int i = 0; i < n; i++) begin
                b  = d[n-1-i];
                ok = (!m_op[29] || sm[n-1-i]) && (b || !(m_op[28] || m_op[1])) &&
                     (base + i < BUFN);
                if (ok) begin
                    exp_addr[exp_n] = 32'(base + i);
                    exp_dat[exp_n]  = b ? (unit ? 8'd1 : fg) : (unit ? 8'd0 : bg);
                    exp_n++;
                end
            end
        end
    endtask

    task automatic run_req(input logic [31:0] d, input int sz, input logic [31:0] p,
                           input int rw, input logic [7:0] fg, input logic [7:0] bg,
                           input bit bp);
        string tag;
        int    got, cyc;
        bit    fin, held;
        logic [AW-1:0] h_addr;
        logic [7:0]    h_dat;
        tag = tag_of(m_mode[31:16]);
        build_expect(d, sz, p, rw, fg, bg);
        @(negedge clk);
        check(req_ready === 1'b1, "R12", "ready while idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_data = d; req_size = 3'(sz); req_pos = p;
        req_row = 10'(rw); fg_color = fg; bg_color = bg;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready === 1'b0, "R12", "ready during request", 32'(req_ready), 32'd0);
        got = 0; cyc = 0; fin = 1'b0; held = 1'b0;
        while (!fin) begin
            pix_ready = bp ? (cyc % 3 != 1) : 1'b1;
            if (held) begin
                check(pix_valid && pix_addr == h_addr && pix_data == h_dat, "R12",
                      "stalled write changed", 32'(pix_addr), 32'(h_addr));
            end
            held = pix_valid && !pix_ready;
            h_addr = pix_addr; h_dat = pix_data;
            if (pix_valid && pix_ready) begin
                if (got < exp_n) begin
                    check(32'(pix_addr) == exp_addr[got], tag, "pixel address",
                          32'(pix_addr), exp_addr[got]);
                    check(pix_data == exp_dat[got], tag, "pixel data",
                          32'(pix_data), 32'(exp_dat[got]));
                    check(pix_wmask == m_plane, "R13", "write mask",
                          32'(pix_wmask), 32'(m_plane));
                end else begin
                    check(1'b0, tag, "extra pixel write", 32'(pix_addr), 32'hffff_ffff);
                end
                mem[pix_addr] = pix_data;
                got++;
            end
            if (done) begin
                fin = 1'b1;
                check(got == exp_n, tag, "pixel count", 32'(got), 32'(exp_n));
                check(next_pos == exp_pos, tag, "returned position", next_pos, exp_pos);
            end else begin
                @(negedge clk);
                cyc++;
                if (cyc > 300) begin
                    check(1'b0, "R12", "request never finished", 32'(cyc), 32'd300);
                    fin = 1'b1;
                end
            end
        end
        pix_ready = 1'b1;
        @(negedge clk);
        check(done === 1'b0, "R12", "done longer than one cycle", 32'(done), 32'd0);
    endtask

    logic [31:0] mode_set [0:6] = '{32'h3ba0_4400, 32'hbbe0_0001, 32'h1360_0000,
                                    32'h13a0_ffff, 32'h2ea0_0000, 32'h28a0_1234,
                                    32'h1234_0000};
    logic [31:0] op_set   [0:4] = '{32'h2300_0300, 32'h0000_0000, 32'h1000_0000,
                                    32'h0000_0002, 32'h3000_0002};
    logic [31:0] mask_set [0:2] = '{32'hffff_ffff, 32'ha5f0_0f3c, 32'h5000_ff00};
    logic [31:0] pos_set  [0:3] = '{32'h0000_0810, 32'h0000_f838, 32'h0003_e0e0,
                                    32'h0000_07fe};
    int          size_set [0:2] = '{1, 2, 4};

    initial begin
        int iter;
        repeat (3) @(negedge clk);
        // R1: reset values seen at the ports
        check(pix_wmask == 8'hff, "R1", "plane mask after reset", 32'(pix_wmask), 32'hff);
        check(pix_valid == 1'b0, "R1", "pixel valid after reset", 32'(pix_valid), 32'd0);
        check(done == 1'b0, "R1", "done after reset", 32'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
        // R1: access mode resets to 0, so nothing is written and position holds
        run_req(32'hdead_beef, 4, 32'h0000_0100, 0, 8'h11, 8'h22, 1'b0);
        // R1: image op resets with bit 29 set, so the mask gates bytes
        cfg_write(2'd0, 32'h1360_0000);
        cfg_write(2'd1, 32'h5000_0000);
        run_req(32'h1122_3344, 4, 32'h0000_0820, 1, 8'h00, 8'h00, 1'b0);
        // R13: plane mask shows on the write enable
        cfg_write(2'd3, 32'h0000_005a);
        check(pix_wmask == 8'h5a, "R13", "plane mask write", 32'(pix_wmask), 32'h5a);
        iter = 0;
        for (int mi = 0; mi < 7; mi++) begin
            cfg_write(2'd0, mode_set[mi]);
            for (int oi = 0; oi < 5; oi++) begin
                cfg_write(2'd2, op_set[oi]);
                cfg_write(2'd3, 32'(8'h0f + 8'(oi * 37)));
                for (int ki = 0; ki < 3; ki++) begin
                    cfg_write(2'd1, mask_set[ki]);
                    for (int si = 0; si < 3; si++) begin
                        for (int pi = 0; pi < 4; pi++) begin
                            run_req(32'hc3a5_0f96 ^ (32'(iter) * 32'h0101_0101),
                                    size_set[si], pos_set[pi], (pi == 0) ? 2 : 0,
                                    8'h3c ^ 8'(iter), 8'hc1, iter[0]);
                            iter++;
                        end
                    end
                end
            end
        end
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        end
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog expired actual=%0d expected=finished", 190000);
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        end
        $finish;
    end

endmodule